// File: doc/BRIEF.md
# Single-Decoder Turbo Iteration Scheduler

This block lets one soft-in soft-out trellis decoder serve both constituent codes of a rate-1/3 parallel concatenated code. A frame of soft values is loaded: a systematic stream and two parity streams, each signed 5 bits per position. The block then runs a fixed number of iterations. Each iteration has two half-iterations that run one after the other. In the first half-iteration the decoder sees the data in natural order with the first parity stream. In the second it sees the systematic data in interleaved order with the second parity stream. The a-priori value sent with each position is the extrinsic result from the previous half-iteration.

The decoder itself is outside the block. It sits behind a streaming port and returns one soft output a fixed number of cycles after each input. A delay line carries the matching address, systematic value and a-priori value, so that the extrinsic value (decoder output minus a-priori minus the scaled systematic value) can be formed and written back. The extrinsic store is held in natural order. Interleaving therefore becomes a permuted read, and de-interleaving a write to the permuted address. After the last half-iteration, the sign of each a-posteriori value is kept at its natural position and streamed out.

Top module: `turbo_sched_ctrl`

## Requirements
- R1: While reset is asserted, `in_ready`, `dec_valid` and `out_valid` are low. `in_ready` goes high within two cycles after reset is released.
- R2: While `in_ready` is high, each cycle with `in_valid` stores one position, starting at index 0. The cycle after the FRAME_LEN-th store, `in_ready` is low. `in_valid` while `in_ready` is low has no effect on any output.
- R3: A first half-iteration is FRAME_LEN consecutive `dec_valid` cycles. Cycle j carries systematic[j], parity1[j] and a-priori[j].
- R4: A second half-iteration is FRAME_LEN consecutive `dec_valid` cycles. Cycle j carries systematic[p(j)], parity2[j] and a-priori[p(j)], where p(j) = (ILV_MUL*j + ILV_ADD) mod FRAME_LEN. FRAME_LEN is a power of two and ILV_MUL is odd; the defaults are 21 and 5.
- R5: For each decoder result, extrinsic = llr − a-priori − (systematic << SYS_SHIFT), saturated to the signed EXT_W range (−128..127 by default). It replaces a-priori at the same natural position (j in the first half-iteration, p(j) in the second) and is used in the next half-iteration.
- R6: Each decoder result is taken exactly DEC_LAT cycles after its input. `dec_llr_valid` must coincide with that cycle, and no write-back happens without it.
- R7: Consecutive half-iterations, and the last half-iteration and the output burst, are separated by exactly DEC_LAT cycles with `dec_valid` and `out_valid` low. A frame has 2*ITERS half-iterations, first half-iteration first.
- R8: The first half-iteration of every frame sends a-priori value 0 at all positions, whatever earlier frames left behind.
- R9: The output is FRAME_LEN consecutive `out_valid` cycles in natural order. `out_bit` is 1 when that position's decoder output in the last second half-iteration was negative (sign bit set). `in_ready` is high the cycle after the last output.
- R10: At most one of `in_ready`, `dec_valid` and `out_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame load strobe |
| in_ready | output | 1 | Block is accepting frame positions |
| in_sys | input | SOFT_W | Soft systematic value, signed |
| in_par1 | input | SOFT_W | Soft parity value, first code, signed |
| in_par2 | input | SOFT_W | Soft parity value, second code, signed |
| dec_valid | output | 1 | Decoder input valid |
| dec_sys | output | SOFT_W | Systematic value to decoder |
| dec_par | output | SOFT_W | Parity value to decoder |
| dec_apri | output | EXT_W | A-priori value to decoder |
| dec_llr_valid | input | 1 | Decoder soft output valid |
| dec_llr | input | LLR_W | Decoder soft output (a-posteriori), signed |
| out_valid | output | 1 | Hard decision valid |
| out_bit | output | 1 | Hard decision, natural order |

## Verification
The assertions check four things on every cycle. The three handshake flags must be mutually exclusive. `in_ready` may drop only after an accepted sample. The decoder's result strobe must line up with the internal latency delay line. Every decoder burst and every output burst must be exactly one frame long, and the output burst must start after an idle gap and return to loading. Only the bench's scenarios can show that the values are right. It follows the permuted reads and the de-interleaving writes through all iterations, and checks that the a-priori store is cleared between frames. It also drives saturation in both directions with extreme inputs, checks that samples offered while busy are ignored, and checks recovery from a reset in the middle of a frame.

// File: rtl/turbo_sched_pkg.sv
`timescale 1ns/1ps
package turbo_sched_pkg;

  // Scheduler phases
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_OUT   = 2'd3
  } sched_st_e;

endpackage

// File: rtl/turbo_perm_map.sv
`timescale 1ns/1ps
// Constant permutation p(i) = (MUL*i + ADD) mod N, built as a table.
module turbo_perm_map #(
  parameter int N   = 64,
  parameter int AW  = 6,
  parameter int MUL = 21,
  parameter int ADD = 5
) (
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] perm
);

  logic [AW-1:0] tbl [N];

  for (genvar i = 0; i < N; i++) begin : g_tbl
    localparam int unsigned ENTRY = (MUL * i + ADD) % N;
    assign tbl[i] = AW'(ENTRY);
  end

  assign perm = tbl[idx];

endmodule

// File: rtl/turbo_frame_store.sv
`timescale 1ns/1ps
// Frame storage: soft inputs, natural-order a-priori values, hard decisions.
module turbo_frame_store #(
  parameter int N  = 64,
  parameter int AW = 6,
  parameter int SW = 5,
  parameter int EW = 8
) (
  input  logic          clk,
  // frame load
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [SW-1:0] ld_sys,
  input  logic [SW-1:0] ld_par1,
  input  logic [SW-1:0] ld_par2,
  // extrinsic write-back
  input  logic          xw_we,
  input  logic [AW-1:0] xw_addr,
  input  logic [EW-1:0] xw_ext,
  input  logic          hd_we,
  input  logic          hd_bit,
  // reads
  input  logic [AW-1:0] rd_pos_addr,
  input  logic [AW-1:0] rd_step_addr,
  input  logic          rd_sel2,
  output logic [SW-1:0] rd_sys,
  output logic [SW-1:0] rd_par,
  output logic [EW-1:0] rd_apri,
  output logic          rd_hard
);

  logic [SW-1:0] sys_m  [N];
  logic [SW-1:0] par1_m [N];
  logic [SW-1:0] par2_m [N];
  logic [EW-1:0] apri_m [N];
  logic [N-1:0]  hard_m;

  always_ff @(posedge clk) begin
    if (ld_we) begin
      sys_m[ld_addr]  <= ld_sys;
      par1_m[ld_addr] <= ld_par1;
      par2_m[ld_addr] <= ld_par2;
    end
  end

  // a-priori cleared while loading, overwritten by extrinsic otherwise
  always_ff @(posedge clk) begin
    if (ld_we) begin
      apri_m[ld_addr] <= '0;
    end else if (xw_we) begin
      apri_m[xw_addr] <= xw_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (hd_we) begin
      hard_m[xw_addr] <= hd_bit;
    end
  end

  assign rd_sys  = sys_m[rd_pos_addr];
  assign rd_apri = apri_m[rd_pos_addr];
  assign rd_par  = rd_sel2 ? par2_m[rd_step_addr] : par1_m[rd_step_addr];
  assign rd_hard = hard_m[rd_step_addr];

endmodule

// File: rtl/turbo_ext_calc.sv
`timescale 1ns/1ps
// Latency-matched delay line plus saturating extrinsic subtraction.
module turbo_ext_calc #(
  parameter int AW    = 6,
  parameter int SW    = 5,
  parameter int EW    = 8,
  parameter int LW    = 10,
  parameter int LAT   = 3,
  parameter int SHIFT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_valid,
  input  logic [AW-1:0] is_addr,
  input  logic [SW-1:0] is_sys,
  input  logic [EW-1:0] is_apri,
  input  logic [LW-1:0] llr,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [EW-1:0] wr_ext
);

  localparam int DW = LW + SW + SHIFT + 2;

  logic [LAT-1:0] v_d, v_q;
  logic [AW-1:0]  a_d [LAT];
  logic [AW-1:0]  a_q [LAT];
  logic [SW-1:0]  s_d [LAT];
  logic [SW-1:0]  s_q [LAT];
  logic [EW-1:0]  p_d [LAT];
  logic [EW-1:0]  p_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign v_d[g] = is_valid;
      assign a_d[g] = is_addr;
      assign s_d[g] = is_sys;
      assign p_d[g] = is_apri;
    end else begin : g_body
      assign v_d[g] = v_q[g-1];
      assign a_d[g] = a_q[g-1];
      assign s_d[g] = s_q[g-1];
      assign p_d[g] = p_q[g-1];
    end

    // data stages, clock enabled by the stage's valid
    always_ff @(posedge clk) begin
      if (v_d[g]) begin
        a_q[g] <= a_d[g];
        s_q[g] <= s_d[g];
        p_q[g] <= p_d[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q <= v_d;
    end
  end

  logic signed [DW-1:0] llr_x, apri_x, sys_x, diff, hi_lim, lo_lim;

  assign llr_x  = {{(DW-LW){llr[LW-1]}}, llr};
  assign apri_x = {{(DW-EW){p_q[LAT-1][EW-1]}}, p_q[LAT-1]};
  assign sys_x  = {{(DW-SW){s_q[LAT-1][SW-1]}}, s_q[LAT-1]};
  assign diff   = llr_x - apri_x - (sys_x <<< SHIFT);
  assign hi_lim = DW'((2 ** (EW - 1)) - 1);
  assign lo_lim = ~hi_lim;

  always_comb begin
    if (diff > hi_lim) begin
      wr_ext = {1'b0, {(EW-1){1'b1}}};
    end else if (diff < lo_lim) begin
      wr_ext = {1'b1, {(EW-1){1'b0}}};
    end else begin
      wr_ext = diff[EW-1:0];
    end
  end

  assign wr_valid = v_q[LAT-1];
  assign wr_addr  = a_q[LAT-1];

endmodule

// File: rtl/turbo_sched_ctrl.sv
`timescale 1ns/1ps
// Time-shared single-decoder turbo iteration scheduler (top).
module turbo_sched_ctrl
  import turbo_sched_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int ITERS     = 4,
  parameter int SOFT_W    = 5,
  parameter int EXT_W     = 8,
  parameter int LLR_W     = 10,
  parameter int DEC_LAT   = 3,
  parameter int SYS_SHIFT = 1,
  parameter int ILV_MUL   = 21,
  parameter int ILV_ADD   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SOFT_W-1:0] in_sys,
  input  logic [SOFT_W-1:0] in_par1,
  input  logic [SOFT_W-1:0] in_par2,
  output logic              dec_valid,
  output logic [SOFT_W-1:0] dec_sys,
  output logic [SOFT_W-1:0] dec_par,
  output logic [EXT_W-1:0]  dec_apri,
  input  logic              dec_llr_valid,
  input  logic [LLR_W-1:0]  dec_llr,
  output logic              out_valid,
  output logic              out_bit
);

  localparam int AW = $clog2(FRAME_LEN);
  localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam int GW = (DEC_LAT > 1) ? $clog2(DEC_LAT) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] LAST_IT  = IW'(ITERS - 1);
  localparam logic [GW-1:0] LAST_GAP = GW'(DEC_LAT - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  // scheduler state
  sched_st_e     st_q, st_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [IW-1:0] iter_q, iter_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          half_q, half_d;
  logic          step_en;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    iter_d = iter_q;
    gap_d  = gap_q;
    half_d = half_q;
    unique case (st_q)
      ST_LOAD: begin
        if (in_valid) begin
          if (idx_q == LAST_IDX) begin
            st_d   = ST_RUN;
            idx_d  = '0;
            half_d = 1'b0;
            iter_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (idx_q == LAST_IDX) begin
          st_d  = ST_DRAIN;
          idx_d = '0;
          gap_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (gap_q == LAST_GAP) begin
          if (!half_q) begin
            st_d   = ST_RUN;
            half_d = 1'b1;
          end else if (iter_q == LAST_IT) begin
            st_d = ST_OUT;
          end else begin
            st_d   = ST_RUN;
            half_d = 1'b0;
            iter_d = iter_q + 1'b1;
          end
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      ST_OUT: begin
        if (idx_q == LAST_IDX) begin
          st_d  = ST_LOAD;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_LOAD;
    endcase
  end

  assign step_en = (st_q != ST_LOAD) || in_valid;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_LOAD;
      idx_q  <= '0;
      iter_q <= '0;
      gap_q  <= '0;
      half_q <= 1'b0;
    end else if (step_en) begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      iter_q <= iter_d;
      gap_q  <= gap_d;
      half_q <= half_d;
    end
  end

  // addressing
  logic [AW-1:0] perm_idx, pos_addr;

  turbo_perm_map #(
    .N   (FRAME_LEN),
    .AW  (AW),
    .MUL (ILV_MUL),
    .ADD (ILV_ADD)
  ) u_perm (
    .idx  (idx_q),
    .perm (perm_idx)
  );

  assign pos_addr = half_q ? perm_idx : idx_q;

  // storage and extrinsic path
  logic              issuing, ld_we;
  logic              ext_wr_valid, wb_we, hd_we;
  logic [AW-1:0]     ext_wr_addr;
  logic [EXT_W-1:0]  ext_val;
  logic [SOFT_W-1:0] rd_sys, rd_par;
  logic [EXT_W-1:0]  rd_apri;
  logic              rd_hard;

  assign issuing = (st_q == ST_RUN);
  assign ld_we   = in_valid && in_ready;
  assign wb_we   = ext_wr_valid && dec_llr_valid;
  assign hd_we   = wb_we && half_q && (iter_q == LAST_IT);

  turbo_frame_store #(
    .N  (FRAME_LEN),
    .AW (AW),
    .SW (SOFT_W),
    .EW (EXT_W)
  ) u_store (
    .clk          (clk),
    .ld_we        (ld_we),
    .ld_addr      (idx_q),
    .ld_sys       (in_sys),
    .ld_par1      (in_par1),
    .ld_par2      (in_par2),
    .xw_we        (wb_we),
    .xw_addr      (ext_wr_addr),
    .xw_ext       (ext_val),
    .hd_we        (hd_we),
    .hd_bit       (dec_llr[LLR_W-1]),
    .rd_pos_addr  (pos_addr),
    .rd_step_addr (idx_q),
    .rd_sel2      (half_q),
    .rd_sys       (rd_sys),
    .rd_par       (rd_par),
    .rd_apri      (rd_apri),
    .rd_hard      (rd_hard)
  );

  turbo_ext_calc #(
    .AW    (AW),
    .SW    (SOFT_W),
    .EW    (EXT_W),
    .LW    (LLR_W),
    .LAT   (DEC_LAT),
    .SHIFT (SYS_SHIFT)
  ) u_ext (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .is_valid (issuing),
    .is_addr  (pos_addr),
    .is_sys   (rd_sys),
    .is_apri  (rd_apri),
    .llr      (dec_llr),
    .wr_valid (ext_wr_valid),
    .wr_addr  (ext_wr_addr),
    .wr_ext   (ext_val)
  );

  // port outputs
  assign in_ready  = rst_int_n && (st_q == ST_LOAD);
  assign dec_valid = issuing;
  assign dec_sys   = rd_sys;
  assign dec_par   = rd_par;
  assign dec_apri  = rd_apri;
  assign out_valid = (st_q == ST_OUT);
  assign out_bit   = rd_hard;

endmodule

// File: rtl/turbo_sched_ctrl_chk.sv
`timescale 1ns/1ps
module turbo_sched_ctrl_chk #(
  parameter int FRAME_LEN = 64
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic dec_valid,
  input logic out_valid,
  input logic dec_llr_valid,
  input logic ext_wr_valid
);

  logic [15:0] dec_run, out_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_run <= '0;
      out_run <= '0;
    end else begin
      dec_run <= dec_valid ? dec_run + 16'd1 : 16'd0;
      out_run <= out_valid ? out_run + 16'd1 : 16'd0;
    end
  end

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, dec_valid, out_valid}));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));

  // R6
  llr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_llr_valid == ext_wr_valid);

  // R3
  dec_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dec_valid) |-> (dec_run == 16'(FRAME_LEN)));

  // R9
  out_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (out_run == 16'(FRAME_LEN)) && in_ready);

  // R7
  out_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(dec_valid));

endmodule

bind turbo_sched_ctrl turbo_sched_ctrl_chk #(
  .FRAME_LEN (FRAME_LEN)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .dec_valid     (dec_valid),
  .out_valid     (out_valid),
  .dec_llr_valid (dec_llr_valid),
  .ext_wr_valid  (ext_wr_valid)
);

// File: tb/turbo_sched_ctrl_tb.sv
`timescale 1ns/1ps
module turbo_sched_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 64;
  localparam int ITS   = 4;
  localparam int LAT   = 3;
  localparam int SHIFT = 1;
  localparam int PMUL  = 21;
  localparam int PADD  = 5;
  localparam int WD_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [4:0] in_sys, in_par1, in_par2;
  logic       dec_valid;
  logic [4:0] dec_sys, dec_par;
  logic [7:0] dec_apri;
  logic       dec_llr_valid;
  logic [9:0] dec_llr;
  logic       out_valid, out_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  turbo_sched_ctrl #(
    .FRAME_LEN (N), .ITERS (ITS), .SOFT_W (5), .EXT_W (8), .LLR_W (10),
    .DEC_LAT (LAT), .SYS_SHIFT (SHIFT), .ILV_MUL (PMUL), .ILV_ADD (PADD)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_sys (in_sys), .in_par1 (in_par1), .in_par2 (in_par2),
    .dec_valid (dec_valid), .dec_sys (dec_sys), .dec_par (dec_par),
    .dec_apri (dec_apri), .dec_llr_valid (dec_llr_valid), .dec_llr (dec_llr),
    .out_valid (out_valid), .out_bit (out_bit)
  );

  // decoder stand-in: llr = 3*sys + 2*par + 2*apri, LAT cycles later
  logic [LAT-1:0] stub_v;
  logic [9:0]     stub_l [LAT];

  function automatic int stub_fn(int s, int p, int a);
    return 3 * s + 2 * p + 2 * a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stub_v <= '0;
    end else begin
      stub_v[0] <= dec_valid;
      stub_l[0] <= 10'(stub_fn($signed(dec_sys), $signed(dec_par), $signed(dec_apri)));
      for (int i = 1; i < LAT; i++) begin
        stub_v[i] <= stub_v[i-1];
        stub_l[i] <= stub_l[i-1];
      end
    end
  end
  assign dec_llr_valid = stub_v[LAT-1];
  assign dec_llr       = stub_l[LAT-1];

  // reference model
  typedef struct {
    bit    dv;
    int    ds;
    int    dp;
    int    da;
    bit    ov;
    bit    ob;
    string tag;
  } exp_t;

  exp_t q[$];
  int   fs [N];
  int   fp1 [N];
  int   fp2 [N];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   armed = 0;
  bit   idle_chk = 0;

  function automatic int perm(int j);
    return (PMUL * j + PADD) % N;
  endfunction

  function automatic int sat8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic build_expect();
    int ap [N];
    bit hd [N];
    exp_t e;
    for (int j = 0; j < N; j++) ap[j] = 0;
    q.delete();
    for (int it = 0; it < ITS; it++) begin
      for (int h = 0; h < 2; h++) begin
        for (int j = 0; j < N; j++) begin
          int a, p, l;
          a = (h == 1) ? perm(j) : j;
          p = (h == 1) ? fp2[j] : fp1[j];
          l = stub_fn(fs[a], p, ap[a]);
          e.dv = 1; e.ds = fs[a]; e.dp = p; e.da = ap[a]; e.ov = 0; e.ob = 0;
          if (h == 1) e.tag = "R4 R5 R6";
          else if (it == 0) e.tag = "R3 R8";
          else e.tag = "R3 R5";
          q.push_back(e);
          ap[a] = sat8(l - ap[a] - (fs[a] << SHIFT));
          if (h == 1 && it == ITS - 1) hd[a] = (l < 0);
        end
        for (int g = 0; g < LAT; g++) begin
          e.dv = 0; e.ds = 0; e.dp = 0; e.da = 0; e.ov = 0; e.ob = 0;
          e.tag = "R7 R2";
          q.push_back(e);
        end
      end
    end
    for (int j = 0; j < N; j++) begin
      e.dv = 0; e.ds = 0; e.dp = 0; e.da = 0; e.ov = 1; e.ob = hd[j];
      e.tag = "R9";
      q.push_back(e);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      if (cyc >= 2) begin
        n_cmp++;
        if (in_ready || dec_valid || out_valid) begin
          n_bad++;
          $display("FAIL R1: reset flags rdy/dv/ov actual %b%b%b expected 000",
                   in_ready, dec_valid, out_valid);
        end
      end
    end else if (armed) begin
      exp_t e;
      bit ok;
      e = q.pop_front();
      ok = !in_ready && (dec_valid == e.dv) && (out_valid == e.ov);
      if (e.dv && ok)
        ok = ($signed(dec_sys) == e.ds) && ($signed(dec_par) == e.dp) &&
             ($signed(dec_apri) == e.da);
      if (e.ov && ok) ok = (out_bit == e.ob);
      n_cmp++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s R10: actual rdy=%b dv=%b s=%0d p=%0d a=%0d ov=%b b=%b expected rdy=0 dv=%b s=%0d p=%0d a=%0d ov=%b b=%b",
                 e.tag, in_ready, dec_valid, $signed(dec_sys), $signed(dec_par),
                 $signed(dec_apri), out_valid, out_bit,
                 e.dv, e.ds, e.dp, e.da, e.ov, e.ob);
      end
      if (q.size() == 0) armed = 0;
    end else if (idle_chk) begin
      n_cmp++;
      if (!in_ready || dec_valid || out_valid) begin
        n_bad++;
        $display("FAIL R2 R10: loading flags rdy/dv/ov actual %b%b%b expected 100",
                 in_ready, dec_valid, out_valid);
      end
    end
  end

  task automatic fill_frame(int mode);
    for (int j = 0; j < N; j++) begin
      case (mode)
        1: begin fs[j] = -16; fp1[j] = -16; fp2[j] = -16; end
        2: begin fs[j] = 15;  fp1[j] = 15;  fp2[j] = 15;  end
        3: begin
             fs[j]  = (j % 2 == 0) ? 9 : -11;
             fp1[j] = (j % 3 == 0) ? -7 : 4;
             fp2[j] = (j % 5 == 0) ? 12 : -3;
           end
        default: begin
             fs[j]  = int'($urandom_range(0, 31)) - 16;
             fp1[j] = int'($urandom_range(0, 31)) - 16;
             fp2[j] = int'($urandom_range(0, 31)) - 16;
           end
      endcase
    end
  endtask

  task automatic load_frame(bit gaps);
    build_expect();
    for (int j = 0; j < N; j++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sys = 5'h0a; in_par1 = 5'h15; in_par2 = 5'h03;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sys = 5'(fs[j]); in_par1 = 5'(fp1[j]); in_par2 = 5'(fp2[j]);
    end
    @(posedge clk);
    armed = 1;
  endtask

  // R2: junk offered while busy must be ignored
  task automatic run_frame(int mode, bit gaps, bit do_reset);
    int n;
    fill_frame(mode);
    load_frame(gaps);
    n = 0;
    do begin
      @(negedge clk);
      in_valid = 1'($urandom_range(0, 1));
      in_sys = 5'($urandom); in_par1 = 5'($urandom); in_par2 = 5'($urandom);
      n++;
      if (do_reset && n == 150) break;
    end while (armed);
    in_valid = 1'b0;
    if (do_reset) begin
      @(posedge clk);
      #1;
      idle_chk = 0;
      armed = 0;
      q.delete();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      idle_chk = 1;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL R9: watchdog expired, actual cycles %0d expected fewer than %0d",
             WD_CYCLES, WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sys = '0; in_par1 = '0; in_par2 = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_chk = 1;
    run_frame(0, 1'b1, 1'b0);   // random, gaps in loading
    run_frame(1, 1'b0, 1'b0);   // negative extremes, saturation low
    run_frame(2, 1'b0, 1'b0);   // positive extremes, saturation high
    run_frame(0, 1'b0, 1'b1);   // reset in the middle of a frame
    run_frame(3, 1'b1, 1'b0);   // structured pattern after reset
    run_frame(0, 1'b0, 1'b0);   // a-priori must start at zero again
    summary();
    $finish;
  end

endmodule